// File: doc/BRIEF.md
# Switching Clock Source Selector

This block derives the switching clock of a power controller from a fast system clock. A period counter divides the system clock, and the output is high for the first half of each period. A configuration input, already decoded to two bits, is latched each time enable rises and selects one of three modes.

In output mode the block free-runs at the default frequency and drives that clock out on a sync pin, with an output enable. In input mode it measures the external sync clock in system-clock cycles. It locks once the measured periods are steady, and each external rising edge then restarts the switching period. Auto-detect mode does the same. If no usable clock arrives, auto-detect mode instead runs at a frequency chosen by the static level of the sync pin, and that level is captured only once after power-on reset.

If the locked external clock stops, the block keeps switching at the last measured period.

Top module: `sw_clk_select`

## Requirements
- R1: While `en` is low, on the next clock `status` is 0 (idle), and `sw_clk`, `sync_out`, `sync_oe` and `ext_locked` are all 0.
- R2: `cfg_mode` is decoded as follows: 2'b01 is output mode, 2'b00 is input mode, and any other value is auto-detect. In output mode `status` is 4 and `sync_oe` is 1. `sw_clk` has a period of 125 cycles (400 kHz at 50 MHz) and `sync_out` equals `sw_clk`. Activity on `sync_in` never causes a lock.
- R3: When enable rises in input or auto-detect mode, `status` becomes 1 (detecting) and the block looks for rising edges on `sync_in`.
- R4: A period is the number of cycles between two successive `sync_in` rising edges. The block locks (`status` 2, `ext_locked` 1) on the edge that completes three consecutive in-range periods, where each period differs from the one before it by at most 2 cycles.
- R5: A period is in range only if it is between 36 and 250 cycles inclusive (about 200 kHz to 1.4 MHz). Any period outside that range clears the run of agreeing periods, so such a clock never locks.
- R6: While locked, each external rising edge restarts the `sw_clk` period, so `sw_clk` goes high on the cycle after the edge. The period follows the latest in-range measurement.
- R7: If no rising edge arrives within twice the locked period, or if an out-of-range period is measured while locked, `status` becomes 3 (holdover). `sw_clk` then keeps the last locked period.
- R8: If no lock occurs within 500 cycles without a rising edge, the block falls back. Input mode goes to `status` 4 with a 125-cycle period. Auto-detect mode goes to `status` 5 with the strap period.
- R9: `strap` is decoded as follows: 2'b00 (low) gives 50 cycles (1 MHz), 2'b01 (high) gives 125 cycles (400 kHz), and any other value (open) gives 250 cycles (200 kHz). It is captured only at the first enable after reset. Later changes have no effect until the next reset.
- R10: In every running state, `sw_clk` is high for floor(P/2) cycles of each P-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; a rising edge starts mode selection and detection |
| cfg_mode | input | 2 | Decoded three-level mode strap |
| strap | input | 2 | Decoded static level of the sync pin, used for the auto-detect frequency |
| sync_in | input | 1 | External sync clock |
| sw_clk | output | 1 | Switching clock |
| sync_out | output | 1 | Clock driven onto the sync pin in output mode |
| sync_oe | output | 1 | Output enable for the sync pin |
| ext_locked | output | 1 | Locked to the external clock |
| status | output | 3 | 0 idle, 1 detect, 2 locked, 3 holdover, 4 internal default, 5 strap |

## Verification
The bench targets four kinds of corner case:
- Clocks that must not lock: periods of 30 and 300 cycles, and a 100/110 alternation that breaks the 2-cycle tolerance. A wrong range check or tolerance would report a lock on one of these.
- Locking at exactly the third agreeing period. An off-by-one count would lock one edge early or late, which the per-cycle comparison exposes.
- Loss of clock. A design that falls back to the default period would show 125 instead of the measured 100.
- Re-enabling with a changed strap. A design that re-samples the strap would switch from 250 to 50 cycles.

// File: rtl/sw_clk_select.sv
module sw_clk_select #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int F_DEF   = 400_000,
  parameter int F_SLOW  = 200_000,
  parameter int F_FAST  = 1_400_000,
  parameter int F_OPEN  = 200_000,
  parameter int F_LOW   = 1_000_000,
  parameter int TOL     = 2,
  parameter int LOCK_N  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] strap,
  input  logic       sync_in,
  output logic       sw_clk,
  output logic       sync_out,
  output logic       sync_oe,
  output logic       ext_locked,
  output logic [2:0] status
);
  localparam int MIN_P  = (CLK_HZ + F_FAST - 1) / F_FAST;
  localparam int MAX_P  = CLK_HZ / F_SLOW;
  localparam int DEF_P  = CLK_HZ / F_DEF;
  localparam int OPEN_P = CLK_HZ / F_OPEN;
  localparam int LOW_P  = CLK_HZ / F_LOW;
  localparam int PW = $clog2(MAX_P + 1);
  localparam int CW = $clog2(2 * MAX_P + 1);
  localparam int GW = $clog2(LOCK_N + 1);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_DET = 3'd1, S_LOCK = 3'd2,
    S_HOLD = 3'd3, S_INT = 3'd4, S_STRAP = 3'd5
  } st_t;

  localparam logic [1:0] M_LOW  = 2'b00;
  localparam logic [1:0] M_HIGH = 2'b01;

  st_t st;
  logic          sync_q, seen, strap_done;
  logic [1:0]    mode_q, strap_q;
  logic [PW-1:0] per, ph, lastp;
  logic [CW-1:0] cnt;
  logic [GW-1:0] good;

  function automatic logic [PW-1:0] strap_per(input logic [1:0] s);
    if (s == M_LOW)       return PW'(LOW_P);
    else if (s == M_HIGH) return PW'(DEF_P);
    else                  return PW'(OPEN_P);
  endfunction

  wire           edge_w = sync_in & ~sync_q;
  wire           auto_m = (mode_q != M_LOW) && (mode_q != M_HIGH);
  wire [CW-1:0]  meas   = cnt + CW'(1);
  wire [CW-1:0]  lp     = CW'(lastp);
  wire [CW-1:0]  dlt    = (meas >= lp) ? meas - lp : lp - meas;
  wire           in_rng = (meas >= CW'(MIN_P)) && (meas <= CW'(MAX_P));
  wire [CW:0]    lim    = (st == S_LOCK) ? ((CW+1)'(per) << 1) : (CW+1)'(2 * MAX_P);
  wire           tmo    = {1'b0, meas} >= lim;

  logic [GW-1:0] good_n;
  always_comb begin
    if (!in_rng)                 good_n = '0;
    else if (good == '0)         good_n = GW'(1);
    else if (dlt <= CW'(TOL))    good_n = good + GW'(1);
    else                         good_n = GW'(1);
  end

  wire lock_now = (st == S_DET) && edge_w && seen && (good_n == GW'(LOCK_N));
  wire ph_align = lock_now || ((st == S_LOCK) && edge_w && in_rng);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sync_q <= 1'b0; seen <= 1'b0; strap_done <= 1'b0;
      mode_q <= M_LOW; strap_q <= 2'b10; per <= PW'(DEF_P);
      lastp <= '0; cnt <= '0; good <= '0;
    end else begin
      sync_q <= sync_in;
      if (!en) st <= S_IDLE;
      else case (st)
        S_IDLE: begin
          mode_q <= cfg_mode; per <= PW'(DEF_P);
          cnt <= '0; good <= '0; seen <= 1'b0;
          if (!strap_done) begin strap_q <= strap; strap_done <= 1'b1; end
          st <= (cfg_mode == M_HIGH) ? S_INT : S_DET;
        end
        S_DET: begin
          if (edge_w) begin
            cnt <= '0;
            if (!seen) seen <= 1'b1;
            else begin
              good <= good_n; lastp <= meas[PW-1:0];
              if (lock_now) begin st <= S_LOCK; per <= meas[PW-1:0]; end
            end
          end else if (tmo) begin
            st  <= auto_m ? S_STRAP : S_INT;
            per <= auto_m ? strap_per(strap_q) : PW'(DEF_P);
          end else cnt <= meas;
        end
        S_LOCK: begin
          if (edge_w) begin
            cnt <= '0;
            if (in_rng) per <= meas[PW-1:0];
            else        st  <= S_HOLD;
          end else if (tmo) st <= S_HOLD;
          else cnt <= meas;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ph <= '0;
    else if (!en || st == S_IDLE)    ph <= '0;
    else if (ph_align)               ph <= '0;
    else if (ph >= per - PW'(1))     ph <= '0;
    else                             ph <= ph + PW'(1);
  end

  assign sw_clk     = (st != S_IDLE) && (ph < (per >> 1));
  assign sync_oe    = (st == S_INT) && (mode_q == M_HIGH);
  assign sync_out   = sync_oe & sw_clk;
  assign ext_locked = (st == S_LOCK);
  assign status     = st;

  a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (status == 3'd0 && !sw_clk && !sync_oe));
  a_r2_oe_needs_output_mode: assert property (@(posedge clk) disable iff (!rst_n)
    sync_oe |-> (mode_q == M_HIGH && !ext_locked));
  a_r4_lock_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_locked) |-> $past(edge_w));
  a_r5_locked_period_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_locked) |-> (per >= PW'(MIN_P) && per <= PW'(MAX_P)));
  a_r7_holdover_keeps_period: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && en) |=> $stable(per));
  a_r9_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_q));
endmodule

// File: tb/sw_clk_select_tb.sv
`timescale 1ns/1ps
module sw_clk_select_tb;
  logic clk = 0, rst_n = 0, en = 0, sync_in = 0;
  logic [1:0] cfg_mode = 2'b00, strap = 2'b10;
  logic sw_clk, sync_out, sync_oe, ext_locked;
  logic [2:0] status;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sw_clk_select u_dut (.clk, .rst_n, .en, .cfg_mode, .strap, .sync_in,
    .sw_clk, .sync_out, .sync_oe, .ext_locked, .status);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_err++; $display("FAIL %s act=%0d exp=%0d", req, act, exp); end
  endtask

  // behavioural reference model
  int m_st, m_per, m_cnt, m_ph, m_good, m_seen, m_lastp, m_mode, m_strap, m_sdone, m_prev;
  always @(posedge clk) begin
    int e, meas, inr, gn, ost, oper, align, ad, sp;
    if (!rst_n) begin
      m_st = 0; m_per = 125; m_cnt = 0; m_ph = 0; m_good = 0; m_seen = 0;
      m_lastp = 0; m_mode = 0; m_strap = 2; m_sdone = 0; m_prev = 0;
    end else begin
      e = (sync_in && !m_prev); meas = m_cnt + 1; inr = (meas >= 36 && meas <= 250);
      ost = m_st; oper = m_per; align = 0;
      ad = (m_mode != 0 && m_mode != 1);
      sp = (m_strap == 0) ? 50 : (m_strap == 1) ? 125 : 250;
      if (!en) m_st = 0;
      else if (ost == 0) begin
        m_mode = cfg_mode; m_per = 125; m_cnt = 0; m_good = 0; m_seen = 0;
        if (!m_sdone) begin m_strap = strap; m_sdone = 1; end
        m_st = (cfg_mode == 1) ? 4 : 1;
      end else if (ost == 1) begin
        if (e) begin
          m_cnt = 0;
          if (!m_seen) m_seen = 1;
          else begin
            if (!inr) gn = 0;
            else if (m_good == 0) gn = 1;
            else if ((meas > m_lastp ? meas - m_lastp : m_lastp - meas) <= 2) gn = m_good + 1;
            else gn = 1;
            m_good = gn; m_lastp = meas;
            if (gn == 3) begin m_st = 2; m_per = meas; align = 1; end
          end
        end else if (meas >= 500) begin
          m_st = ad ? 5 : 4; m_per = ad ? sp : 125;
        end else m_cnt = meas;
      end else if (ost == 2) begin
        if (e) begin
          m_cnt = 0;
          if (inr) begin m_per = meas; align = 1; end else m_st = 3;
        end else if (meas >= 2 * m_per) m_st = 3;
        else m_cnt = meas;
      end
      if (!en || ost == 0) m_ph = 0;
      else if (align) m_ph = 0;
      else if (m_ph >= oper - 1) m_ph = 0;
      else m_ph++;
      m_prev = sync_in;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int msw, moe;
    msw = (m_st != 0 && m_ph < m_per / 2);
    moe = (m_st == 4 && m_mode == 1);
    chk(status == m_st, "R3 model status", status, m_st);
    chk(ext_locked == (m_st == 2), "R4 model lock", ext_locked, m_st == 2);
    chk(sw_clk == msw, "R6 model sw_clk", sw_clk, msw);
    chk(sync_oe == moe, "R2 model sync_oe", sync_oe, moe);
    chk(sync_out == (msw && moe), "R2 model sync_out", sync_out, msw && moe);
  end

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 0; en = 0; sync_in = 0; wait_n(3); rst_n = 1; wait_n(1);
  endtask

  task automatic pulse(input int p);
    sync_in = 1; wait_n(p / 2); sync_in = 0; wait_n(p - p / 2);
  endtask

  task automatic pulses(input int p, input int n);
    for (int i = 0; i < n; i++) pulse(p);
  endtask

  task automatic measure(output int per, output int hi);
    logic prev = sw_clk; int lim = 0;
    per = 0; hi = 0;
    @(negedge clk);
    while (!(sw_clk && !prev) && lim < 2000) begin prev = sw_clk; @(negedge clk); lim++; end
    do begin per++; if (sw_clk) hi++; @(negedge clk); end while (!sw_clk && per < 2000 || (sw_clk && per < 2000 && hi == per));
  endtask

  initial begin
    #(200000 * 20);
    done = 1; n_chk++; n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int p, h;
    do_reset();
    chk(status == 0 && !sw_clk && !sync_oe && !ext_locked, "R1 reset state", status, 0);

    // output mode
    cfg_mode = 2'b01; en = 1; wait_n(3);
    chk(status == 4, "R2 output mode status", status, 4);
    chk(sync_oe == 1, "R2 oe in output mode", sync_oe, 1);
    pulses(100, 8);
    chk(!ext_locked, "R2 no lock in output mode", ext_locked, 0);
    measure(p, h);
    chk(p == 125, "R2 default period", p, 125);
    chk(h == 62, "R10 duty high time", h, 62);

    // input mode lock, track, holdover
    do_reset(); cfg_mode = 2'b00; en = 1; wait_n(2);
    chk(status == 1, "R3 detect after enable", status, 1);
    pulses(100, 3);
    chk(!ext_locked, "R4 no lock before third period", ext_locked, 0);
    pulses(100, 1);
    chk(ext_locked && status == 2, "R4 locked on third period", status, 2);
    fork pulses(100, 6); measure(p, h); join
    chk(p == 100, "R6 locked period", p, 100);
    wait_n(250);
    chk(status == 3, "R7 holdover on loss", status, 3);
    measure(p, h);
    chk(p == 100, "R7 holdover keeps last period", p, 100);
    chk(h == 50, "R10 holdover duty", h, 50);
    en = 0; wait_n(2);
    chk(status == 0 && !sw_clk, "R1 idle after disable", status, 0);

    // input mode, no clock
    do_reset(); cfg_mode = 2'b00; en = 1; wait_n(510);
    chk(status == 4, "R8 input timeout status", status, 4);
    measure(p, h);
    chk(p == 125, "R8 input fallback period", p, 125);

    // range and tolerance
    do_reset(); cfg_mode = 2'b00; en = 1; wait_n(2);
    pulses(30, 10);
    chk(status == 1, "R5 too fast never locks", status, 1);
    pulses(300, 3);
    chk(status == 1, "R5 too slow never locks", status, 1);
    for (int i = 0; i < 6; i++) pulse((i % 2) ? 110 : 100);
    chk(status == 1, "R4 tolerance exceeded no lock", status, 1);
    for (int i = 0; i < 6; i++) pulse((i % 2) ? 101 : 100);
    chk(ext_locked, "R4 small jitter locks", ext_locked, 1);

    // auto-detect, strap frequencies
    do_reset(); cfg_mode = 2'b10; strap = 2'b10; en = 1; wait_n(510);
    chk(status == 5, "R8 auto timeout to strap", status, 5);
    measure(p, h);
    chk(p == 250, "R9 open strap period", p, 250);
    en = 0; strap = 2'b00; wait_n(3); en = 1; wait_n(510);
    measure(p, h);
    chk(p == 250, "R9 strap not resampled", p, 250);
    do_reset(); cfg_mode = 2'b10; strap = 2'b00; en = 1; wait_n(510);
    measure(p, h);
    chk(p == 50, "R9 low strap period", p, 50);
    do_reset(); cfg_mode = 2'b11; strap = 2'b01; en = 1; wait_n(510);
    measure(p, h);
    chk(p == 125, "R9 high strap period", p, 125);

    // auto-detect with a clock present
    do_reset(); cfg_mode = 2'b10; en = 1; wait_n(2);
    chk(status == 1, "R3 auto detect starts", status, 1);
    pulses(50, 6);
    chk(ext_locked, "R3 auto locks to external", ext_locked, 1);
    en = 0; wait_n(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule